// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge function. Software reaches it through one byte-wide port: a byte address, a write strobe with write data, and a read data output. Every byte follows one write rule. It can be read-only, stored through a per-bit keep mask (bits outside the mask become zero), or write-one-to-clear. A write-one-to-clear bit is set by a hardware status input and cleared by software.

A 16-bit aperture base, which forms address bits 31:16 of a memory window, is held together with a 4-bit size code. After every write that touches either of them, the base is trimmed to the alignment that the code selects. The SMRAM control byte and the four shadow control bytes are also driven out as ports, so that neighbouring decode logic can use them. A write takes effect at the next clock edge. A read returns the addressed byte combinationally.

Top module: `bridge_cfg_space`

## Requirements
- R1: After reset, offsets 0x00..0x03 read 0xB9, 0x10, 0x21, 0x16 (vendor 0x10B9, device 0x1621). Offset 0x06 reads 0x10 and 0x08 reads 0x01. Offsets 0x09, 0x0A and 0x0B read 0x00, 0x00 and 0x06. Writes to all of these bytes are ignored.
- R2: Offsets 0x04 and 0x05 reset to 0x06 and 0x00. A write stores wdata AND 0x01.
- R3: Offset 0x07 resets to 0x04. A high stat_set_i[n] sets bit n+4. Writing 1 to any of bits 7:4 clears that bit, and writing 0 leaves it unchanged. Bits 3:0 ignore writes. In a cycle with both a set and a clear, the set wins.
- R4: Offset 0x66 resets to 0x00. err_set_i[1:0] sets bits 1:0 and err_set_i[3:2] sets bits 5:4. Writing 1 to those bits clears them. Bits 7:6 and 3:2 stay 0.
- R5: The aperture base bits 31:16 read at 0x13 (high byte) and 0x12 (low byte), both resetting to 0. Offset 0x13 accepts all bits; offset 0x12 accepts only bits 7:6.
- R6: Offset 0xBC stores the low nibble of a write as the size code and reads bits 7:4 as 0. Codes 1..4 align the base to 1, 2, 4 and 8 MB (clearing base bits 3:0, 4:0, 5:0 and 6:0). Codes 6..10 align it to 16..256 MB (clearing base bits 7:0 up to 11:0). Code 0 and every other code clear the whole base.
- R7: Any write to 0x12, 0x13 or 0xBC stores the new value first and then applies the mask of the resulting code to the resulting base.
- R8: Offsets 0x6C..0x7B are four 32-bit DRAM row descriptors. All of their bits are writable. Each descriptor's bytes reset to 0xFF, 0xFF, 0x00, 0xE0, except that 0x6F resets to 0xE6. Descriptor bits 22:20 (bits 6:4 of the third byte) are the row-size code, stored as written.
- R9: Offset 0x83 (SMRAM control) resets to 0x08. A write stores wdata AND 0xFC. smram_ctl_o always equals the stored byte.
- R10: Offsets 0x84..0x86 (shadow control) are fully writable. Offset 0x87 keeps wdata AND 0x3F. All four reset to 0. shadow_ctl_o = {0x87, 0x86, 0x85, 0x84}.
- R11: Offset 0x0D keeps wdata AND 0xF8 (reset 0). Offset 0x34 is fully writable with reset 0xB0. Offsets 0x40..0x4F are fully writable, except 0x4B, which keeps AND 0x0F. In that range, 0x40 and 0x41 reset to 0x0C, 0x4C and 0x4D to 0x04, 0x4E and 0x4F to 0x7F, and the rest to 0. Offsets 0xF0..0xFF are fully writable and reset by address bits 1:0 to 0x20, 0x43, 0x21, 0x43.
- R12: Every other offset reads 0x00 and ignores writes.
- R13: A write is captured at one rising clock edge and can be read back right after that edge. rdata_o follows addr_i with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Byte address for both read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Byte at addr_i |
| stat_set_i | input | 4 | Sets status bits 7:4 of offset 0x07 |
| err_set_i | input | 4 | Sets the write-one-to-clear bits of offset 0x66 |
| smram_ctl_o | output | 8 | Stored SMRAM control byte |
| shadow_ctl_o | output | 32 | Stored shadow control bytes 0x87..0x84 |

## Verification
The bench builds the block with its default 8-bit address. At that width the whole 256-byte space is small enough to cover completely. Every offset is checked for its reset value and then written with four patterns, each compared against an arithmetic model of its write rule. All sixteen size codes are applied to a full base to expose the alignment table, including the unused codes. Separate sequences cover re-masking on a code change, the set-versus-clear priority of the status bits, and the exported control bytes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_AW   = 8;
  localparam int CFG_DW   = 8;
  localparam int CODE_W   = 4;
  localparam int BASE_W   = 16;
  localparam logic [7:0] APER_LO   = 8'h12;
  localparam logic [7:0] APER_HI   = 8'h13;
  localparam logic [7:0] APER_CODE = 8'hBC;
  localparam logic [7:0] LO_KEEP   = 8'hC0;

  typedef enum logic [1:0] {WK_RO, WK_MASK, WK_W1C, WK_APER} wkind_e;

  typedef struct packed {
    wkind_e     kind;
    logic [7:0] wmask;
    logic [7:0] rstv;
  } reg_pol_t;

  function automatic reg_pol_t mk(wkind_e k, logic [7:0] m, logic [7:0] r);
    reg_pol_t p;
    p.kind = k; p.wmask = m; p.rstv = r;
    return p;
  endfunction

  // Write rule and reset value for each byte offset.
  function automatic reg_pol_t pol_of(logic [7:0] a);
    logic [7:0] rv;
    case (a[1:0])
      2'd0: rv = 8'h20;
      2'd1: rv = 8'h43;
      2'd2: rv = 8'h21;
      default: rv = 8'h43;
    endcase
    if (a == 8'h00) return mk(WK_RO, 8'h00, 8'hB9);
    if (a == 8'h01) return mk(WK_RO, 8'h00, 8'h10);
    if (a == 8'h02) return mk(WK_RO, 8'h00, 8'h21);
    if (a == 8'h03) return mk(WK_RO, 8'h00, 8'h16);
    if (a == 8'h04) return mk(WK_MASK, 8'h01, 8'h06);
    if (a == 8'h05) return mk(WK_MASK, 8'h01, 8'h00);
    if (a == 8'h06) return mk(WK_RO, 8'h00, 8'h10);
    if (a == 8'h07) return mk(WK_W1C, 8'hF0, 8'h04);
    if (a == 8'h08) return mk(WK_RO, 8'h00, 8'h01);
    if (a == 8'h0B) return mk(WK_RO, 8'h00, 8'h06);
    if (a == 8'h0D) return mk(WK_MASK, 8'hF8, 8'h00);
    if (a == APER_LO || a == APER_HI || a == APER_CODE) return mk(WK_APER, 8'h00, 8'h00);
    if (a == 8'h34) return mk(WK_MASK, 8'hFF, 8'hB0);
    if (a == 8'h40 || a == 8'h41) return mk(WK_MASK, 8'hFF, 8'h0C);
    if (a == 8'h4B) return mk(WK_MASK, 8'h0F, 8'h00);
    if (a == 8'h4C || a == 8'h4D) return mk(WK_MASK, 8'hFF, 8'h04);
    if (a == 8'h4E || a == 8'h4F) return mk(WK_MASK, 8'hFF, 8'h7F);
    if (a >= 8'h42 && a <= 8'h4A) return mk(WK_MASK, 8'hFF, 8'h00);
    if (a == 8'h66) return mk(WK_W1C, 8'h33, 8'h00);
    if (a == 8'h6F) return mk(WK_MASK, 8'hFF, 8'hE6);
    if (a >= 8'h6C && a <= 8'h7B) begin
      case (a[1:0])
        2'd0, 2'd1: return mk(WK_MASK, 8'hFF, 8'hFF);
        2'd2:       return mk(WK_MASK, 8'hFF, 8'h00);
        default:    return mk(WK_MASK, 8'hFF, 8'hE0);
      endcase
    end
    if (a == 8'h83) return mk(WK_MASK, 8'hFC, 8'h08);
    if (a >= 8'h84 && a <= 8'h86) return mk(WK_MASK, 8'hFF, 8'h00);
    if (a == 8'h87) return mk(WK_MASK, 8'h3F, 8'h00);
    if (a >= 8'hF0) return mk(WK_MASK, 8'hFF, rv);
    return mk(WK_RO, 8'h00, 8'h00);
  endfunction

  // Alignment mask over base bits 31:16 for a size code.
  function automatic logic [BASE_W-1:0] aper_mask(logic [CODE_W-1:0] c);
    logic [BASE_W-1:0] ones;
    ones = '1;
    if (c >= 4'd1 && c <= 4'd4) return ones << (int'(c) + 3);
    if (c >= 4'd6 && c <= 4'd10) return ones << (int'(c) + 2);
    return '0;
  endfunction
endpackage

// File: rtl/cfg_byte_cell.sv
module cfg_byte_cell #(
  parameter cfg_pkg::wkind_e KIND  = cfg_pkg::WK_RO,
  parameter logic [7:0]      WMASK = 8'h00,
  parameter logic [7:0]      RSTV  = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [7:0] wdata,
  input  logic [7:0] set_bits,
  output logic [7:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RSTV;
    end else begin
      case (KIND)
        cfg_pkg::WK_MASK: if (hit) q <= wdata & WMASK;
        cfg_pkg::WK_W1C:  q <= (q & ~({8{hit}} & wdata & WMASK)) | (set_bits & WMASK);
        default:          q <= q;
      endcase
    end
  end
endmodule

// File: rtl/cfg_aperture.sv
module cfg_aperture
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        lo_o,
  output logic [7:0]        hi_o,
  output logic [7:0]        code_o
);
  logic [BASE_W-1:0] base_q, nb;
  logic [CODE_W-1:0] code_q, nc;
  logic              upd;

  always_comb begin
    nb  = base_q;
    nc  = code_q;
    upd = 1'b0;
    if (wr_en && addr == APER_LO)   begin nb[7:0]  = wdata & LO_KEEP;  upd = 1'b1; end
    if (wr_en && addr == APER_HI)   begin nb[15:8] = wdata;            upd = 1'b1; end
    if (wr_en && addr == APER_CODE) begin nc       = wdata[CODE_W-1:0]; upd = 1'b1; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      code_q <= '0;
    end else if (upd) begin
      base_q <= nb & aper_mask(nc);
      code_q <= nc;
    end
  end

  assign lo_o   = base_q[7:0];
  assign hi_o   = base_q[15:8];
  assign code_o = {{(8-CODE_W){1'b0}}, code_q};

  // R7: stored base never holds a bit below the alignment of the stored code
  p_aper_align_r7: assert property (@(posedge clk) disable iff (rst)
    (base_q & ~aper_mask(code_q)) == '0);
  // R5: low base bits 5:0 never become set
  p_lo_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (base_q[5:0] == 6'd0));
endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space
  import cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [3:0]        stat_set_i,
  input  logic [3:0]        err_set_i,
  output logic [7:0]        smram_ctl_o,
  output logic [31:0]       shadow_ctl_o
);
  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0][7:0] bytes_q;
  logic [7:0] ap_lo, ap_hi, ap_code;

  cfg_aperture u_aper (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en_i),
    .addr   (addr_i),
    .wdata  (wdata_i),
    .lo_o   (ap_lo),
    .hi_o   (ap_hi),
    .code_o (ap_code)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam reg_pol_t P = pol_of(8'(i));
    if (P.kind == WK_APER) begin : g_ap
      if (i == int'(APER_LO)) begin : g_lo
        assign bytes_q[i] = ap_lo;
      end else if (i == int'(APER_HI)) begin : g_hi
        assign bytes_q[i] = ap_hi;
      end else begin : g_code
        assign bytes_q[i] = ap_code;
      end
    end else begin : g_cell
      logic [7:0] set_v;
      if (i == 8'h07) begin : g_sts
        assign set_v = {stat_set_i, 4'b0000};
      end else if (i == 8'h66) begin : g_err
        assign set_v = {2'b00, err_set_i[3:2], 2'b00, err_set_i[1:0]};
      end else begin : g_none
        assign set_v = 8'h00;
      end
      cfg_byte_cell #(.KIND(P.kind), .WMASK(P.wmask), .RSTV(P.rstv)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .hit      (wr_en_i && addr_i == ADDR_W'(i)),
        .wdata    (wdata_i),
        .set_bits (set_v),
        .q        (bytes_q[i])
      );
    end
  end

  assign rdata_o      = bytes_q[addr_i];
  assign smram_ctl_o  = bytes_q[8'h83];
  assign shadow_ctl_o = {bytes_q[8'h87], bytes_q[8'h86], bytes_q[8'h85], bytes_q[8'h84]};

  // R1: vendor high byte always reads back its fixed value
  p_id_ro_r1: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADDR_W'(8'h01)) |-> (rdata_o == 8'h10));
  // R2: after a command write only bit 0 may be set
  p_cmd_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(8'h04)) |=> (bytes_q[8'h04][7:1] == 7'd0));
  // R3: a status bit rises only after its set input was high
  p_sts_rise_r3: assert property (@(posedge clk) disable iff (rst)
    ((bytes_q[8'h07][7:4] & ~$past(bytes_q[8'h07][7:4]) & ~$past(stat_set_i)) == 4'h0));
  // R9: exported SMRAM byte drops bits 1:0 of a write
  p_smram_bits_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(8'h83)) |=> (smram_ctl_o[1:0] == 2'b00));
  // R12: an unimplemented offset reads zero
  p_unimp_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADDR_W'(8'h20)) |-> (rdata_o == 8'h00));
  // R13: a full write lands in one clock
  p_wr_lands_r13: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(8'h40)) |=> (bytes_q[8'h40] == $past(wdata_i)));
endmodule

// File: tb/tb_bridge_cfg_space.sv
module tb_bridge_cfg_space;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr_i = 8'h00;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic [3:0]  stat_set_i = 4'h0;
  logic [3:0]  err_set_i = 4'h0;
  logic [7:0]  smram_ctl_o;
  logic [31:0] shadow_ctl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_cfg_space dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .stat_set_i(stat_set_i), .err_set_i(err_set_i),
    .smram_ctl_o(smram_ctl_o), .shadow_ctl_o(shadow_ctl_o)
  );

  function automatic string tag(int a);
    if (a <= 3 || a == 6 || (a >= 8 && a <= 11)) return "R1";
    if (a == 4 || a == 5) return "R2";
    if (a == 7) return "R3";
    if (a == 'h66) return "R4";
    if (a == 'h12 || a == 'h13) return "R5";
    if (a == 'hBC) return "R6";
    if (a >= 'h6C && a <= 'h7B) return "R8";
    if (a == 'h83) return "R9";
    if (a >= 'h84 && a <= 'h87) return "R10";
    if (a == 'h0D || a == 'h34 || (a >= 'h40 && a <= 'h4F) || a >= 'hF0) return "R11";
    return "R12";
  endfunction

  function automatic logic [7:0] exp_rst(int a);
    case (a)
      'h00: return 8'hB9; 'h01: return 8'h10; 'h02: return 8'h21; 'h03: return 8'h16;
      'h04: return 8'h06; 'h06: return 8'h10; 'h07: return 8'h04; 'h08: return 8'h01;
      'h0B: return 8'h06; 'h34: return 8'hB0; 'h40, 'h41: return 8'h0C;
      'h4C, 'h4D: return 8'h04; 'h4E, 'h4F: return 8'h7F; 'h83: return 8'h08;
      'h6F: return 8'hE6;
      default: ;
    endcase
    if (a >= 'h6C && a <= 'h7B) begin
      if (a % 4 == 0 || a % 4 == 1) return 8'hFF;
      if (a % 4 == 2) return 8'h00;
      return 8'hE0;
    end
    if (a >= 'hF0) return (a % 4 == 0) ? 8'h20 : (a % 4 == 2) ? 8'h21 : 8'h43;
    return 8'h00;
  endfunction

  // kind: 0 ignore, 1 keep-mask, 2 write-one-to-clear
  function automatic void exp_rule(int a, output int kind, output logic [7:0] m);
    kind = 1; m = 8'hFF;
    if (a == 4 || a == 5) m = 8'h01;
    else if (a == 7) begin kind = 2; m = 8'hF0; end
    else if (a == 'h66) begin kind = 2; m = 8'h33; end
    else if (a == 'h0D) m = 8'hF8;
    else if (a == 'h4B) m = 8'h0F;
    else if (a == 'h83) m = 8'hFC;
    else if (a == 'h87) m = 8'h3F;
    else if (a == 'h34 || (a >= 'h40 && a <= 'h4F) || (a >= 'h6C && a <= 'h7B) ||
             (a >= 'h84 && a <= 'h86) || a >= 'hF0) m = 8'hFF;
    else begin kind = 0; m = 8'h00; end
  endfunction

  function automatic logic [15:0] exp_mask(int c);
    if (c >= 1 && c <= 4) return 16'hFFFF << (c + 3);
    if (c >= 6 && c <= 10) return 16'hFFFF << (c + 2);
    return 16'h0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    addr_i = a;
    #1;
    chk(req, {24'h0, rdata_o}, {24'h0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h5A; pats[3] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // Reset values over the whole space
    for (int a = 0; a < 256; a++) begin
      model[a] = exp_rst(a);
      rd_chk(tag(a), 8'(a), model[a]);
    end
    chk("R9", {24'h0, smram_ctl_o}, 32'h08);
    chk("R10", shadow_ctl_o, 32'h0);

    // Write sweep with four patterns, aperture bytes excluded
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 256; a++) begin
        int k; logic [7:0] m;
        if (a == 'h12 || a == 'h13 || a == 'hBC) continue;
        exp_rule(a, k, m);
        wr(8'(a), pats[p]);
        if (k == 1) model[a] = pats[p] & m;
        else if (k == 2) model[a] = model[a] & ~(pats[p] & m);
        rd_chk({tag(a), " R13"}, 8'(a), model[a]);
      end
    end

    // R8: row-size field stored as written
    wr(8'h6E, 8'h60);
    rd_chk("R8", 8'h6E, 8'h60);

    // R9, R10: exported bytes
    wr(8'h83, 8'hFF);
    chk("R9", {24'h0, smram_ctl_o}, 32'hFC);
    wr(8'h84, 8'h11); wr(8'h85, 8'h22); wr(8'h86, 8'h33); wr(8'h87, 8'hFF);
    chk("R10", shadow_ctl_o, 32'h3F332211);

    // R3: set, selective clear, write of zero, set-wins
    @(negedge clk) stat_set_i = 4'hF;
    @(negedge clk) stat_set_i = 4'h0;
    rd_chk("R3", 8'h07, 8'hF4);
    wr(8'h07, 8'h5F);
    rd_chk("R3", 8'h07, 8'hA4);
    wr(8'h07, 8'h00);
    rd_chk("R3", 8'h07, 8'hA4);
    @(negedge clk);
    addr_i = 8'h07; wdata_i = 8'hA0; wr_en_i = 1'b1; stat_set_i = 4'h2;
    @(negedge clk);
    wr_en_i = 1'b0; stat_set_i = 4'h0;
    rd_chk("R3", 8'h07, 8'h24);

    // R4: set and clear of 0x66
    @(negedge clk) err_set_i = 4'hF;
    @(negedge clk) err_set_i = 4'h0;
    rd_chk("R4", 8'h66, 8'h33);
    wr(8'h66, 8'hCD);
    rd_chk("R4", 8'h66, 8'h32);
    wr(8'h66, 8'h30);
    rd_chk("R4", 8'h66, 8'h02);

    // R5, R6: every size code against a full base
    for (int c = 0; c < 16; c++) begin
      logic [15:0] eb;
      wr(8'hBC, 8'(8'hF0 | c));
      wr(8'h13, 8'hFF);
      wr(8'h12, 8'hFF);
      eb = 16'hFFC0 & exp_mask(c);
      rd_chk("R6", 8'hBC, 8'(c));
      rd_chk("R5", 8'h13, eb[15:8]);
      rd_chk("R5", 8'h12, eb[7:0]);
    end

    // R7: code change re-trims the held base
    wr(8'hBC, 8'h01); wr(8'h13, 8'hFF); wr(8'h12, 8'hC0);
    rd_chk("R7", 8'h12, 8'hC0);
    wr(8'hBC, 8'h0A);
    rd_chk("R7", 8'h13, 8'hF0);
    rd_chk("R7", 8'h12, 8'h00);
    wr(8'hBC, 8'h00);
    rd_chk("R7", 8'h13, 8'h00);
    wr(8'hBC, 8'h01);
    rd_chk("R7", 8'h13, 8'h00);

    // R13: a held-off write does not land
    @(negedge clk);
    addr_i = 8'h41; wdata_i = 8'h99; wr_en_i = 1'b0;
    @(negedge clk);
    rd_chk("R13", 8'h41, model[8'h41]);

    finish_run();
  end
endmodule